// File: doc/BRIEF.md
# Tiled Bilinear Texel Address Generator

This block turns a fixed-point texture coordinate pair into the four memory addresses a bilinear filter needs. The request carries the level-0 base address, the log2 width and height of the full-resolution image, a mip level and a u/v coordinate in texels of that level. The block returns the byte addresses of the 2×2 texel footprint and the two 8-bit fractional weights that sit between those texels.

Texels are 32-bit words stored tile by tile. Each square tile holds its texels row-major, and the tiles of a level follow one another row-major across the level. The mip levels are packed back to back from level 0 upward. Each level is half the width and height of the one below it, and its storage is padded up to whole tiles. Coordinates that fall outside the level wrap around, so textures repeat.

Requests enter through a valid/ready handshake. Results leave through a second valid/ready handshake after a two-stage pipeline.

Top module: `tex_bilinear_addr_gen`

## Requirements
- R1: After reset, out_valid is 0 and req_ready is 1.
- R2: Texel (x,y) of a level with tiles of edge T has byte address levelbase + 4·((⌊y/T⌋·tilesx + ⌊x/T⌋)·T² + (y mod T)·T + (x mod T)), where tilesx = ⌈levelwidth/T⌉. Every address is therefore a multiple of 4.
- R3: The base of level L is the request base plus, for every level k < L, 4·T²·⌈wk/T⌉·⌈hk/T⌉ bytes.
- R4: Level k has width max(2^wlog2 >> k, 1) and height max(2^hlog2 >> k, 1). A requested level above max(wlog2,hlog2) is treated as that top level (1×1).
- R5: u and v are unsigned with 16 integer and 8 fraction bits. The left texel index is ⌊u − 0.5⌋, and out_frac_u is the low 8 bits of u − 0x80. The same rules apply to v.
- R6: Texel indices wrap modulo the level width and height. This covers a coordinate below one half, whose index becomes width−1, and the right or lower neighbour of the last texel, which becomes 0.
- R7: out_addr0..out_addr3 hold the texels (x0,y0), (x1,y0), (x0,y1), (x1,y1), where x1 = x0+1 and y1 = y0+1 after wrapping.
- R8: A level narrower or shorter than one tile still takes one whole tile of storage in that dimension, and all of its texels lie inside that tile.
- R9: A request accepted at clock edge k shows out_valid from edge k+2. While out_valid is high and out_ready is low, out_valid and all outputs hold.
- R10: Results leave in acceptance order. With both stages full and out_ready low, req_ready is 0. Whenever out_valid is 0, req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_u | input | 24 | u coordinate, 16.8 unsigned, level texels |
| req_v | input | 24 | v coordinate, 16.8 unsigned, level texels |
| req_level | input | 4 | Mip level |
| req_wlog2 | input | 4 | log2 of level-0 width (0..11) |
| req_hlog2 | input | 4 | log2 of level-0 height (0..11) |
| req_base | input | 32 | Byte address of level 0 |
| out_valid | output | 1 | Footprint present |
| out_ready | input | 1 | Consumer takes footprint |
| out_addr0 | output | 32 | Address of (x0,y0) |
| out_addr1 | output | 32 | Address of (x1,y0) |
| out_addr2 | output | 32 | Address of (x0,y1) |
| out_addr3 | output | 32 | Address of (x1,y1) |
| out_frac_u | output | 8 | Horizontal weight |
| out_frac_v | output | 8 | Vertical weight |

## Verification
The bench builds two copies of the block, one with 8-texel tiles and one with 16-texel tiles, and drives both with the same requests. With two tile edges, one texture can be smaller than a tile under one build and span several tiles under the other. This exercises the padding rule and the tile-index arithmetic at both widths. The textures used run from 1×1 to 2048×2048, and include non-square shapes and levels clamped at the top of the pyramid.

// File: rtl/tex_addr_pkg.sv
package tex_addr_pkg;
    parameter int COORD_W  = 24;
    parameter int FRAC_W   = 8;
    parameter int ADDR_W   = 32;
    parameter int LOG_W    = 4;
    parameter int MAX_LOG2 = 11;

    localparam int IDX_W      = COORD_W - FRAC_W;
    localparam int NUM_LEVELS = MAX_LOG2 + 1;
    localparam int NUM_TAPS   = 4;

    typedef struct packed {
        logic [ADDR_W-1:0] lvl_base;
        logic [LOG_W-1:0]  wl;
        logic [IDX_W-1:0]  x0;
        logic [IDX_W-1:0]  x1;
        logic [IDX_W-1:0]  y0;
        logic [IDX_W-1:0]  y1;
        logic [FRAC_W-1:0] fu;
        logic [FRAC_W-1:0] fv;
    } stage_a_t;

    typedef struct packed {
        logic [NUM_TAPS-1:0][ADDR_W-1:0] addr;
        logic [FRAC_W-1:0]               fu;
        logic [FRAC_W-1:0]               fv;
    } stage_b_t;

    typedef struct packed {
        logic     a_vld;
        stage_a_t a;
        logic     b_vld;
        stage_b_t b;
    } pipe_t;
endpackage

// File: rtl/tex_level_base.sv
module tex_level_base
    import tex_addr_pkg::*;
#(
    parameter int TILE_LOG2 = 3
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [LOG_W-1:0]  wlog2,
    input  logic [LOG_W-1:0]  hlog2,
    input  logic [LOG_W-1:0]  level,
    output logic [ADDR_W-1:0] lvl_base,
    output logic [LOG_W-1:0]  wl,
    output logic [LOG_W-1:0]  hl
);
    localparam int TEXEL_SHIFT = 2 * TILE_LOG2 + 2;

    logic [LOG_W-1:0] top_lvl;
    logic [LOG_W-1:0] lvl;

    always_comb begin : base_sum
        int tx;
        int ty;
        top_lvl  = (wlog2 > hlog2) ? wlog2 : hlog2;
        lvl      = (level > top_lvl) ? top_lvl : level;
        wl       = (wlog2 > lvl) ? wlog2 - lvl : '0;
        hl       = (hlog2 > lvl) ? hlog2 - lvl : '0;
        lvl_base = base;
        for (int k = 0; k < NUM_LEVELS; k++) begin
            tx = int'(wlog2) - k - TILE_LOG2;
            ty = int'(hlog2) - k - TILE_LOG2;
            if (tx < 0) tx = 0;
            if (ty < 0) ty = 0;
            if (k < int'(lvl)) begin
                lvl_base = lvl_base + (ADDR_W'(1) << (tx + ty + TEXEL_SHIFT));
            end
        end
    end
endmodule

// File: rtl/tex_axis_wrap.sv
module tex_axis_wrap
    import tex_addr_pkg::*;
(
    input  logic [COORD_W-1:0] coord,
    input  logic [LOG_W-1:0]   dlog,
    output logic [IDX_W-1:0]   i0,
    output logic [IDX_W-1:0]   i1,
    output logic [FRAC_W-1:0]  frac
);
    localparam logic [COORD_W-1:0] HALF = COORD_W'(1) << (FRAC_W - 1);

    logic [COORD_W-1:0] shifted;
    logic [IDX_W-1:0]   mask;

    always_comb begin
        shifted = coord - HALF;
        mask    = IDX_W'((32'd1 << dlog) - 32'd1);
        frac    = shifted[FRAC_W-1:0];
        i0      = shifted[COORD_W-1:FRAC_W] & mask;
        i1      = (i0 + IDX_W'(1)) & mask;
    end
endmodule

// File: rtl/tex_tile_addr.sv
module tex_tile_addr
    import tex_addr_pkg::*;
#(
    parameter int TILE_LOG2 = 3
) (
    input  logic [ADDR_W-1:0] lvl_base,
    input  logic [LOG_W-1:0]  wl,
    input  logic [IDX_W-1:0]  x,
    input  logic [IDX_W-1:0]  y,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [LOG_W-1:0] TL = LOG_W'(TILE_LOG2);

    logic [LOG_W-1:0]       txl;
    logic [IDX_W-1:0]       tile_x;
    logic [IDX_W-1:0]       tile_y;
    logic [ADDR_W-1:0]      tile_idx;
    logic [2*TILE_LOG2-1:0] inner;
    logic [ADDR_W-1:0]      offs;

    always_comb begin
        txl      = (wl > TL) ? wl - TL : '0;
        tile_x   = x >> TILE_LOG2;
        tile_y   = y >> TILE_LOG2;
        tile_idx = (ADDR_W'(tile_y) << txl) | ADDR_W'(tile_x);
        inner    = {y[TILE_LOG2-1:0], x[TILE_LOG2-1:0]};
        offs     = (tile_idx << (2 * TILE_LOG2)) | ADDR_W'(inner);
        addr     = lvl_base + (offs << 2);
    end
endmodule

// File: rtl/tex_bilinear_addr_gen.sv
module tex_bilinear_addr_gen
    import tex_addr_pkg::*;
#(
    parameter int TILE_LOG2 = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [COORD_W-1:0]  req_u,
    input  logic [COORD_W-1:0]  req_v,
    input  logic [LOG_W-1:0]    req_level,
    input  logic [LOG_W-1:0]    req_wlog2,
    input  logic [LOG_W-1:0]    req_hlog2,
    input  logic [ADDR_W-1:0]   req_base,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [ADDR_W-1:0]   out_addr0,
    output logic [ADDR_W-1:0]   out_addr1,
    output logic [ADDR_W-1:0]   out_addr2,
    output logic [ADDR_W-1:0]   out_addr3,
    output logic [FRAC_W-1:0]   out_frac_u,
    output logic [FRAC_W-1:0]   out_frac_v
);
    pipe_t pipe_d, pipe_q;

    logic [ADDR_W-1:0] lb_base;
    logic [LOG_W-1:0]  lb_wl;
    logic [LOG_W-1:0]  lb_hl;

    logic [COORD_W-1:0] ax_coord [2];
    logic [LOG_W-1:0]   ax_dlog  [2];
    logic [IDX_W-1:0]   ax_i0    [2];
    logic [IDX_W-1:0]   ax_i1    [2];
    logic [FRAC_W-1:0]  ax_frac  [2];

    logic [ADDR_W-1:0]  tap_addr [NUM_TAPS];

    logic adv_a, adv_b;

    tex_level_base #(.TILE_LOG2(TILE_LOG2)) u_lvl (
        .base     (req_base),
        .wlog2    (req_wlog2),
        .hlog2    (req_hlog2),
        .level    (req_level),
        .lvl_base (lb_base),
        .wl       (lb_wl),
        .hl       (lb_hl)
    );

    assign ax_coord[0] = req_u;
    assign ax_coord[1] = req_v;
    assign ax_dlog[0]  = lb_wl;
    assign ax_dlog[1]  = lb_hl;

    for (genvar g = 0; g < 2; g++) begin : g_axis
        tex_axis_wrap u_ax (
            .coord (ax_coord[g]),
            .dlog  (ax_dlog[g]),
            .i0    (ax_i0[g]),
            .i1    (ax_i1[g]),
            .frac  (ax_frac[g])
        );
    end

    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        tex_tile_addr #(.TILE_LOG2(TILE_LOG2)) u_tap (
            .lvl_base (pipe_q.a.lvl_base),
            .wl       (pipe_q.a.wl),
            .x        ((g % 2 == 1) ? pipe_q.a.x1 : pipe_q.a.x0),
            .y        ((g / 2 == 1) ? pipe_q.a.y1 : pipe_q.a.y0),
            .addr     (tap_addr[g])
        );
    end

    always_comb begin
        pipe_d = pipe_q;
        adv_b  = !pipe_q.b_vld || out_ready;
        adv_a  = !pipe_q.a_vld || adv_b;
        if (adv_b) begin
            pipe_d.b_vld = pipe_q.a_vld;
            for (int t = 0; t < NUM_TAPS; t++) pipe_d.b.addr[t] = tap_addr[t];
            pipe_d.b.fu = pipe_q.a.fu;
            pipe_d.b.fv = pipe_q.a.fv;
        end
        if (adv_a) begin
            pipe_d.a_vld      = req_valid;
            pipe_d.a.lvl_base = lb_base;
            pipe_d.a.wl       = lb_wl;
            pipe_d.a.x0       = ax_i0[0];
            pipe_d.a.x1       = ax_i1[0];
            pipe_d.a.y0       = ax_i0[1];
            pipe_d.a.y1       = ax_i1[1];
            pipe_d.a.fu       = ax_frac[0];
            pipe_d.a.fv       = ax_frac[1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign req_ready  = adv_a;
    assign out_valid  = pipe_q.b_vld;
    assign out_addr0  = pipe_q.b.addr[0];
    assign out_addr1  = pipe_q.b.addr[1];
    assign out_addr2  = pipe_q.b.addr[2];
    assign out_addr3  = pipe_q.b.addr[3];
    assign out_frac_u = pipe_q.b.fu;
    assign out_frac_v = pipe_q.b.fv;
endmodule

// File: rtl/tex_bilinear_addr_gen_chk.sv
module tex_bilinear_addr_gen_chk
    import tex_addr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ADDR_W-1:0] out_addr0,
    input logic [ADDR_W-1:0] out_addr1,
    input logic [ADDR_W-1:0] out_addr2,
    input logic [ADDR_W-1:0] out_addr3,
    input logic [FRAC_W-1:0] out_frac_u,
    input logic [FRAC_W-1:0] out_frac_v
);
    a_r9_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid);

    a_r9_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> $stable(out_addr0) && $stable(out_addr1)
            && $stable(out_addr2) && $stable(out_addr3)
            && $stable(out_frac_u) && $stable(out_frac_v));

    a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_addr0[1:0] == 2'b00) && (out_addr1[1:0] == 2'b00)
            && (out_addr2[1:0] == 2'b00) && (out_addr3[1:0] == 2'b00));

    a_r10_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> req_ready);

    a_r1_idle_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> !out_valid);
endmodule

bind tex_bilinear_addr_gen tex_bilinear_addr_gen_chk chk_i (.*);

// File: tb/tex_bilinear_addr_gen_tb_top.sv
module tex_bilinear_addr_gen_tb_top;
    typedef struct packed {
        logic [23:0] u;
        logic [23:0] v;
        logic [3:0]  lvl;
        logic [3:0]  wl;
        logic [3:0]  hl;
        logic [31:0] base;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{24'h000180, 24'h000280, 4'd0, 4'd3,  4'd3,  32'h0000_1000},
        '{24'h000A40, 24'h000C80, 4'd0, 4'd6,  4'd5,  32'h0000_0000},
        '{24'h000000, 24'h000010, 4'd0, 4'd5,  4'd5,  32'h0000_2000},
        '{24'h001F80, 24'h001FC0, 4'd0, 4'd5,  4'd5,  32'h0000_0400},
        '{24'h000990, 24'h0011F0, 4'd1, 4'd6,  4'd6,  32'h0001_0000},
        '{24'h00A1A0, 24'h003333, 4'd3, 4'd11, 4'd11, 32'h0010_0000},
        '{24'h000080, 24'h000080, 4'd5, 4'd5,  4'd5,  32'h0000_0000},
        '{24'h000155, 24'h0002AA, 4'd9, 4'd5,  4'd3,  32'h0000_8000},
        '{24'h002F80, 24'h000100, 4'd1, 4'd8,  4'd2,  32'h0000_0000},
        '{24'h012345, 24'h00FEDC, 4'd0, 4'd4,  4'd6,  32'h0004_0000},
        '{24'h0021C0, 24'h000350, 4'd2, 4'd10, 4'd4,  32'h8000_0000},
        '{24'h000480, 24'h000700, 4'd0, 4'd0,  4'd0,  32'h0000_0100}
    };

    logic        clk = 0;
    logic        rst_n = 0;
    logic        req_valid = 0;
    logic [23:0] req_u = '0, req_v = '0;
    logic [3:0]  req_level = '0, req_wlog2 = '0, req_hlog2 = '0;
    logic [31:0] req_base = '0;
    logic        out_ready = 1;

    logic        rdy8, rdy16, ov8, ov16;
    logic [31:0] a8 [4];
    logic [31:0] a16 [4];
    logic [7:0]  fu8, fv8, fu16, fv16;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tex_bilinear_addr_gen #(.TILE_LOG2(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy8),
        .req_u(req_u), .req_v(req_v), .req_level(req_level),
        .req_wlog2(req_wlog2), .req_hlog2(req_hlog2), .req_base(req_base),
        .out_valid(ov8), .out_ready(out_ready),
        .out_addr0(a8[0]), .out_addr1(a8[1]), .out_addr2(a8[2]), .out_addr3(a8[3]),
        .out_frac_u(fu8), .out_frac_v(fv8)
    );

    tex_bilinear_addr_gen #(.TILE_LOG2(4)) dut16_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy16),
        .req_u(req_u), .req_v(req_v), .req_level(req_level),
        .req_wlog2(req_wlog2), .req_hlog2(req_hlog2), .req_base(req_base),
        .out_valid(ov16), .out_ready(out_ready),
        .out_addr0(a16[0]), .out_addr1(a16[1]), .out_addr2(a16[2]), .out_addr3(a16[3]),
        .out_frac_u(fu16), .out_frac_v(fv16)
    );

    function automatic int lvl_dim(int lg, int k);
        int d = (1 << lg) >> k;
        return (d < 1) ? 1 : d;
    endfunction

    function automatic int wrap_idx(logic [23:0] c, int n, int plus);
        int s = int'(c) - 128;
        int i = s >>> 8;
        return (((i % n) + n) % n + plus) % n;
    endfunction

    function automatic logic [31:0] exp_addr(int tl, vec_t t, int tap);
        int T = 1 << tl;
        int top = (t.wl > t.hl) ? int'(t.wl) : int'(t.hl);
        int lv = (int'(t.lvl) > top) ? top : int'(t.lvl);
        longint b = longint'(t.base);
        int w, h, tx, x, y;
        longint off;
        for (int k = 0; k < lv; k++) begin
            w = lvl_dim(int'(t.wl), k);
            h = lvl_dim(int'(t.hl), k);
            b += longint'((w + T - 1) / T) * ((h + T - 1) / T) * T * T * 4;
        end
        w  = lvl_dim(int'(t.wl), lv);
        h  = lvl_dim(int'(t.hl), lv);
        x  = wrap_idx(t.u, w, tap % 2);
        y  = wrap_idx(t.v, h, tap / 2);
        tx = (w + T - 1) / T;
        off = longint'((y / T) * tx + (x / T)) * T * T + (y % T) * T + (x % T);
        return 32'(b + off * 4);
    endfunction

    function automatic logic [7:0] exp_frac(logic [23:0] c);
        return 8'((int'(c) + 128) & 255);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic drive(vec_t t);
        req_u = t.u; req_v = t.v; req_level = t.lvl;
        req_wlog2 = t.wl; req_hlog2 = t.hl; req_base = t.base;
    endtask

    // Called at a negedge; returns at the negedge after the accepting edge.
    task automatic send(vec_t t);
        drive(t);
        req_valid = 1;
        #1;
        while (!rdy8) @(negedge clk);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic check_out(string req, vec_t t);
        for (int p = 0; p < 4; p++) begin
            chk({req, " tile8"},  a8[p],  exp_addr(3, t, p));
            chk({req, " tile16"}, a16[p], exp_addr(4, t, p));
        end
        chk({req, " frac_u"}, 32'(fu8),  32'(exp_frac(t.u)));
        chk({req, " frac_v"}, 32'(fv16), 32'(exp_frac(t.v)));
    endtask

    function automatic string tag_of(int i);
        case (i)
            0: return "R2 R7 basic";
            1: return "R5 frac";
            2: return "R6 low wrap";
            3: return "R6 edge wrap";
            4: return "R3 level1";
            5: return "R3 R4 deep level";
            6: return "R8 1x1 level";
            7: return "R4 clamp";
            8: return "R8 subtile height";
            9: return "R6 far coord";
            10: return "R3 R4 wide";
            default: return "R4 R8 1x1 tex";
        endcase
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: idle state after reset
        chk("R1 out_valid", 32'(ov8), 32'd0);
        chk("R1 req_ready", 32'(rdy8 & rdy16), 32'd1);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            send(VECS[i]);
            chk("R9 latency not yet", 32'(ov8), 32'd0);
            @(negedge clk);
            chk("R9 latency valid", 32'(ov8 & ov16), 32'd1);
            check_out(tag_of(i), VECS[i]);
            @(negedge clk);
        end

        // R9 R10: back-pressure and ordering
        out_ready = 0;
        send(VECS[0]);
        send(VECS[1]);
        drive(VECS[2]);
        req_valid = 1;
        #1;
        chk("R10 full stalls input", 32'(rdy8), 32'd0);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk("R9 held valid", 32'(ov8), 32'd1);
            check_out("R9 held data", VECS[0]);
            chk("R10 still stalled", 32'(rdy16), 32'd0);
        end
        req_valid = 0;
        out_ready = 1;
        @(negedge clk);
        chk("R10 second in order", 32'(ov8), 32'd1);
        check_out("R10 order", VECS[1]);
        @(negedge clk);
        chk("R10 drained", 32'(ov8 | ov16), 32'd0);
        chk("R10 ready when empty", 32'(rdy8), 32'd1);

        // R1: reset clears a pending result
        send(VECS[3]);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset flush", 32'(ov8 | ov16), 32'd0);

        finish_run();
    end
endmodule